// File: doc/BRIEF.md
# Octal Device Control Bridge

The bridge lets a host reach the registers of two downstream octal line devices that have no host port of their own. The host shifts 16-bit words into the bridge one bit at a time, MSB first. The first word of an access is an address word. When it falls in the bridge's page, the bridge turns the access into one 16-bit downstream frame: an 8-bit address byte, then an 8-bit data byte. The frame goes out on a serial link with one active-low chip select per device.

A read starts as soon as its address word is complete. A write first collects one more 16-bit data word and sends only the low byte of it. Read data comes back as a byte and is widened with zeros to 16 bits. A single-cycle `done_o` pulse marks the end of every downstream frame. `busy_o` tells the host when the bridge will drop incoming bits.

Top module: `octl_bridge`

## Requirements
- R1: Host bits are taken on cycles where `hbit_valid_i` is high and form 16-bit words, MSB first. No downstream activity starts before the 16th bit of an address word has been taken.
- R2: An address word is claimed only when its bits 14:8 equal 0x15. Any other read address is dropped. Any other write address is dropped together with the word that follows it, and neither produces a frame.
- R3: Address bit 15 gives the direction, 1 for read and 0 for write. A claimed read starts its frame at once. A claimed write waits for the next word and then starts. Each claimed access produces exactly one frame.
- R4: Address bit 7 picks the device: 0 drives `dev_cs_no[0]` low and 1 drives `dev_cs_no[1]` low. At most one chip select is low at any time.
- R5: A frame is 16 bits, MSB first. The address byte is {direction bit, address bits 6:0}. On a read, the bridge drives the data byte as zeros.
- R6: On a write, the data byte is bits 7:0 of the host data word. Bits 15:8 of that word have no effect on the frame.
- R7: On a read, the bridge samples `dev_miso_i` during the data byte, MSB first. The sampled byte appears on `rdata_o` with bits 15:8 zero.
- R8: `dev_sclk_o` idles low and toggles on every clock cycle while a chip select is low, which is half the system clock rate. A frame has 16 rising edges and keeps its chip select low for 32 cycles. `dev_mosi_o` changes only while `dev_sclk_o` is low. The device changes `dev_miso_i` after a falling edge.
- R9: `done_o` is high for exactly one cycle, in the first cycle after the chip select rises. `rdata_o` changes only together with `done_o` at the end of a read, and a write leaves it unchanged.
- R10: `busy_o` is high from the cycle after a claimed access is complete until the cycle after its frame ends. Host bits presented while `busy_o` is high are dropped. Word alignment is kept across this.
- R11: After reset, both chip selects are high, `dev_sclk_o`, `dev_mosi_o`, `done_o` and `busy_o` are low, and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hbit_valid_i | input | 1 | Host bit strobe |
| hbit_i | input | 1 | Host serial bit, MSB of each word first |
| busy_o | output | 1 | Access in progress; host bits are dropped |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| rdata_o | output | 16 | Last read byte, zero-extended |
| dev_sclk_o | output | 1 | Downstream serial clock |
| dev_mosi_o | output | 1 | Downstream serial data out |
| dev_cs_no | output | 2 | Per-device chip select, active low |
| dev_miso_i | input | 1 | Downstream serial data in |

## Verification
On every cycle, the assertions check the link timing:
- at most one chip select is low;
- the serial clock toggles on every cycle inside a frame;
- MOSI stays still while the clock is high;
- `done_o` is a single-cycle pulse that lines up with the end of a frame;
- no frame runs while `busy_o` is low;
- `rdata_o` holds between pulses.

Some behaviour only the bench scenarios can show, because a device model must capture the frames. These are the frame contents and the chip select used, the page decode and the discard of a foreign write's data word, the truncated and zero-extended data, the stall until the 16th address bit, and the drop of bits sent while busy.

// File: rtl/octl_pkg.sv
package octl_pkg;
  typedef enum logic [1:0] {
    D_ADDR,
    D_DATA,
    D_SKIP,
    D_WAIT
  } dec_state_e;
endpackage

// File: rtl/octl_word_rx.sv
module octl_word_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_d;

  assign sh_d = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q         <= '0;
      cnt_q        <= '0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      word_valid_o <= 1'b0;
      if (enable_i && bit_valid_i) begin
        sh_q <= sh_d;
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          cnt_q        <= '0;
          word_valid_o <= 1'b1;
          word_o       <= sh_d;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/octl_decode.sv
module octl_decode
  import octl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int N_DEV  = 2,
  parameter int PAGE   = 'h15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                word_valid_i,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                xfer_done_i,
  output logic                start_o,
  output logic [2*BYTE_W-1:0] frame_o,
  output logic [$clog2(N_DEV)-1:0] dev_o,
  output logic                rd_o,
  output logic                busy_o
);
  localparam int DEV_W  = $clog2(N_DEV);
  localparam int PAGE_W = WORD_W - BYTE_W - 1;

  dec_state_e        st_q;
  logic [BYTE_W-1:0] addr_lo_q;
  logic              page_hit;
  logic              word_rd;

  assign page_hit = (word_i[WORD_W-2:BYTE_W] == PAGE_W'(PAGE));
  assign word_rd  = word_i[WORD_W-1];
  assign busy_o   = (st_q == D_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= D_ADDR;
      addr_lo_q <= '0;
      start_o   <= 1'b0;
      frame_o   <= '0;
      dev_o     <= '0;
      rd_o      <= 1'b0;
    end else begin
      start_o <= 1'b0;
      unique case (st_q)
        D_ADDR: begin
          if (word_valid_i) begin
            if (page_hit && word_rd) begin
              frame_o <= {1'b1, word_i[BYTE_W-2:0], {BYTE_W{1'b0}}};
              dev_o   <= word_i[BYTE_W-1 -: DEV_W];
              rd_o    <= 1'b1;
              start_o <= 1'b1;
              st_q    <= D_WAIT;
            end else if (page_hit) begin
              addr_lo_q <= word_i[BYTE_W-1:0];
              st_q      <= D_DATA;
            end else if (!word_rd) begin
              st_q <= D_SKIP;  // foreign write: its data word is not ours
            end
          end
        end
        D_DATA: begin
          if (word_valid_i) begin
            frame_o <= {1'b0, addr_lo_q[BYTE_W-2:0], word_i[BYTE_W-1:0]};
            dev_o   <= addr_lo_q[BYTE_W-1 -: DEV_W];
            rd_o    <= 1'b0;
            start_o <= 1'b1;
            st_q    <= D_WAIT;
          end
        end
        D_SKIP: begin
          if (word_valid_i) st_q <= D_ADDR;
        end
        D_WAIT: begin
          if (xfer_done_i) st_q <= D_ADDR;
        end
        default: st_q <= D_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/octl_serial.sv
module octl_serial #(
  parameter int BYTE_W = 8,
  parameter int N_DEV  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [2*BYTE_W-1:0]      frame_i,
  input  logic [$clog2(N_DEV)-1:0] dev_i,
  input  logic                     rd_i,
  input  logic                     miso_i,
  output logic                     sclk_o,
  output logic                     mosi_o,
  output logic [N_DEV-1:0]         cs_no,
  output logic                     done_o,
  output logic [BYTE_W-1:0]        rdata_o
);
  localparam int FRAME_W = 2 * BYTE_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int DEV_W   = $clog2(N_DEV);

  logic               act_q;
  logic [FRAME_W-1:0] tx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  rx_q;
  logic [DEV_W-1:0]   dev_q;
  logic               rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      tx_q    <= '0;
      cnt_q   <= '0;
      rx_q    <= '0;
      dev_q   <= '0;
      rd_q    <= 1'b0;
      sclk_o  <= 1'b0;
      mosi_o  <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q  <= 1'b1;
          tx_q   <= frame_i;
          mosi_o <= frame_i[FRAME_W-1];
          cnt_q  <= '0;
          sclk_o <= 1'b0;
          dev_q  <= dev_i;
          rd_q   <= rd_i;
        end
      end else if (!sclk_o) begin
        sclk_o <= 1'b1;
        rx_q   <= {rx_q[BYTE_W-2:0], miso_i};  // last BYTE_W samples are the data byte
      end else begin
        sclk_o <= 1'b0;
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          act_q  <= 1'b0;
          mosi_o <= 1'b0;
          done_o <= 1'b1;
          if (rd_q) rdata_o <= rx_q;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          tx_q   <= tx_q << 1;
          mosi_o <= tx_q[FRAME_W-2];
        end
      end
    end
  end

  for (genvar g = 0; g < N_DEV; g++) begin : g_cs
    assign cs_no[g] = !(act_q && (dev_q == DEV_W'(g)));
  end
endmodule

// File: rtl/octl_bridge.sv
module octl_bridge #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int N_DEV  = 2,
  parameter int PAGE   = 'h15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hbit_valid_i,
  input  logic              hbit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              dev_sclk_o,
  output logic              dev_mosi_o,
  output logic [N_DEV-1:0]  dev_cs_no,
  input  logic              dev_miso_i
);
  localparam int DEV_W   = $clog2(N_DEV);
  localparam int FRAME_W = 2 * BYTE_W;

  logic               word_valid;
  logic [WORD_W-1:0]  word;
  logic               start;
  logic [FRAME_W-1:0] frame;
  logic [DEV_W-1:0]   dev;
  logic               rd;
  logic [BYTE_W-1:0]  rbyte;

  octl_word_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (!busy_o),
    .bit_valid_i  (hbit_valid_i),
    .bit_i        (hbit_i),
    .word_valid_o (word_valid),
    .word_o       (word)
  );

  octl_decode #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .N_DEV(N_DEV), .PAGE(PAGE)) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid),
    .word_i       (word),
    .xfer_done_i  (done_o),
    .start_o      (start),
    .frame_o      (frame),
    .dev_o        (dev),
    .rd_o         (rd),
    .busy_o       (busy_o)
  );

  octl_serial #(.BYTE_W(BYTE_W), .N_DEV(N_DEV)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .frame_i (frame),
    .dev_i   (dev),
    .rd_i    (rd),
    .miso_i  (dev_miso_i),
    .sclk_o  (dev_sclk_o),
    .mosi_o  (dev_mosi_o),
    .cs_no   (dev_cs_no),
    .done_o  (done_o),
    .rdata_o (rbyte)
  );

  assign rdata_o = {{(WORD_W - BYTE_W){1'b0}}, rbyte};
endmodule

// File: rtl/octl_bridge_chk.sv
module octl_bridge_chk #(
  parameter int WORD_W = 16,
  parameter int N_DEV  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] rdata_o,
  input logic              dev_sclk_o,
  input logic              dev_mosi_o,
  input logic [N_DEV-1:0]  dev_cs_no
);
  logic in_frame;
  assign in_frame = !(&dev_cs_no);

  a_r4_single_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dev_cs_no));

  a_r8_sclk_only_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_sclk_o |-> in_frame);

  a_r8_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && $past(in_frame)) |-> (dev_sclk_o != $past(dev_sclk_o)));

  a_r8_mosi_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_sclk_o |-> $stable(dev_mosi_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!in_frame && $past(in_frame)));

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));

  a_r10_no_frame_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !in_frame);
endmodule

bind octl_bridge octl_bridge_chk #(.WORD_W(WORD_W), .N_DEV(N_DEV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rdata_o    (rdata_o),
  .dev_sclk_o (dev_sclk_o),
  .dev_mosi_o (dev_mosi_o),
  .dev_cs_no  (dev_cs_no)
);

// File: tb/octl_bridge_test.sv
module octl_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hbit_valid = 1'b0;
  logic        hbit = 1'b0;
  logic        busy, done;
  logic [15:0] rdata;
  logic        sclk, mosi;
  logic [1:0]  cs_n;
  logic        miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  // device model state
  logic [15:0] cap = '0;
  logic [1:0]  cap_cs = 2'b11;
  int          nrise = 0;
  logic [7:0]  rd_byte = '0;
  int          cur_len = 0;
  int          last_len = 0;
  int          nxfer = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  octl_bridge uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .hbit_valid_i (hbit_valid),
    .hbit_i       (hbit),
    .busy_o       (busy),
    .done_o       (done),
    .rdata_o      (rdata),
    .dev_sclk_o   (sclk),
    .dev_mosi_o   (mosi),
    .dev_cs_no    (cs_n),
    .dev_miso_i   (miso)
  );

  always @(posedge sclk) begin
    if (cs_n != 2'b11) begin
      cap    = {cap[14:0], mosi};
      cap_cs = cs_n;
      nrise  = nrise + 1;
    end
  end

  always @(negedge sclk) begin
    if (cs_n != 2'b11 && nrise >= 8 && nrise < 16) miso = rd_byte[15 - nrise];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n != 2'b11) cur_len = cur_len + 1;
      else if (cur_len != 0) begin
        last_len = cur_len;
        cur_len  = 0;
        nxfer    = nxfer + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input bit rd, input logic [15:0] a, input logic [15:0] d);
    return {rd, a[6:0], (rd ? 8'h00 : d[7:0])};
  endfunction

  function automatic logic [1:0] exp_cs(input logic [15:0] a);
    return a[7] ? 2'b01 : 2'b10;
  endfunction

  task automatic send_bits(input logic [15:0] w, input int hi, input int lo, input bit gaps);
    for (int i = hi; i >= lo; i--) begin
      @(negedge clk);
      hbit_valid = 1'b1;
      hbit       = w[i];
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int k = 0; k < g; k++) begin
          @(negedge clk);
          hbit_valid = 1'b0;
          hbit       = 1'($urandom_range(0, 1));
        end
      end
    end
    @(negedge clk);
    hbit_valid = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic prep(input logic [7:0] rb);
    rd_byte = rb;
    miso    = 1'b0;
    nrise   = 0;
    cap     = '0;
  endtask

  // full claimed access with frame and result checks
  task automatic do_txn(input bit rd, input logic [6:0] r, input bit dev,
                        input logic [15:0] d, input logic [7:0] rb, input bit gaps);
    logic [15:0] a;
    logic [15:0] prev_rdata;
    int prev_n;
    bit ok;
    a = {rd, 7'h15, dev, r};
    prep(rb);
    prev_rdata = rdata;
    prev_n     = nxfer;
    send_bits(a, 15, 0, gaps);
    if (!rd) send_bits(d, 15, 0, gaps);
    wait_done(ok);
    chk(ok, "R9 done pulse seen", 32'(ok), 1);
    chk(cap == exp_frame(rd, a, d), rd ? "R5 read frame" : "R6 write frame",
        32'(cap), 32'(exp_frame(rd, a, d)));
    chk(cap_cs == exp_cs(a), "R4 chip select", 32'(cap_cs), 32'(exp_cs(a)));
    chk(nrise == 16 && last_len == 32, "R8 frame timing",
        32'(nrise * 256 + last_len), 32'(16 * 256 + 32));
    chk(nxfer == prev_n + 1, "R3 one frame per access", 32'(nxfer), 32'(prev_n + 1));
    if (rd) chk(rdata == {8'h00, rb}, "R7 read data", 32'(rdata), 32'({8'h00, rb}));
    else    chk(rdata == prev_rdata, "R9 write keeps rdata", 32'(rdata), 32'(prev_rdata));
    chk(!busy, "R10 busy low after frame", 32'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_val;
    int prev_n;
    bit ok;
    logic [15:0] prev_rdata;
    seed_val = $urandom(32'h0c7a1);

    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 2'b11 && !sclk && !mosi && !done && !busy && rdata == 16'h0,
        "R11 reset state", {cs_n, sclk, mosi, done, busy, rdata[15:0]}, 32'h00300000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: 15 bits of a read address do nothing
    prep(8'hA5);
    prev_n = nxfer;
    send_bits(16'h9523, 15, 1, 1'b0);
    repeat (40) @(negedge clk);
    chk(nxfer == prev_n && cs_n == 2'b11 && !busy, "R1 no frame before 16th bit",
        32'(nxfer), 32'(prev_n));
    send_bits(16'h9523, 0, 0, 1'b0);
    wait_done(ok);
    chk(ok && cap == 16'hA300 && cap_cs == 2'b10, "R1 frame after 16th bit",
        32'(cap), 32'hA300);
    chk(rdata == 16'h00A5, "R7 zero extension", 32'(rdata), 32'h00A5);

    // R2: foreign write whose data word looks like a claimed read
    prev_n = nxfer;
    prev_rdata = rdata;
    send_bits(16'h1600, 15, 0, 1'b0);
    send_bits(16'h9581, 15, 0, 1'b0);
    repeat (60) @(negedge clk);
    chk(nxfer == prev_n, "R2 foreign write and its data dropped", 32'(nxfer), 32'(prev_n));
    // R2: foreign read
    send_bits(16'h9480, 15, 0, 1'b0);
    send_bits(16'hD5FF, 15, 0, 1'b0);
    repeat (60) @(negedge clk);
    chk(nxfer == prev_n && rdata == prev_rdata, "R2 foreign reads dropped",
        32'(nxfer), 32'(prev_n));

    // boundaries of the page, both devices, upper data byte ignored
    do_txn(1'b0, 7'h00, 1'b0, 16'hFF3C, 8'h00, 1'b0);   // 0x1500
    do_txn(1'b0, 7'h7F, 1'b1, 16'h5AC3, 8'h00, 1'b0);   // 0x15FF, R6
    do_txn(1'b1, 7'h7F, 1'b1, 16'h0000, 8'hFF, 1'b0);
    do_txn(1'b1, 7'h00, 1'b0, 16'h0000, 8'h00, 1'b0);

    // R10: host bits while busy are dropped
    prep(8'h00);
    prev_n = nxfer;
    prev_rdata = rdata;
    send_bits(16'h1522, 15, 0, 1'b0);
    send_bits(16'h0077, 15, 0, 1'b0);
    for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
    chk(busy, "R10 busy during access", 32'(busy), 1);
    send_bits(16'h9511, 15, 0, 1'b0);
    wait_done(ok);
    repeat (60) @(negedge clk);
    chk(nxfer == prev_n + 1 && rdata == prev_rdata, "R10 bits during busy dropped",
        32'(nxfer), 32'(prev_n + 1));
    chk(cap == 16'h2277 && cap_cs == 2'b10, "R10 frame of accepted write",
        32'(cap), 32'h2277);
    do_txn(1'b1, 7'h11, 1'b0, 16'h0000, 8'h3E, 1'b0);   // alignment kept

    // constrained random accesses
    for (int t = 0; t < 40; t++) begin
      do_txn(1'($urandom_range(0, 1)), 7'($urandom_range(0, 127)), 1'($urandom_range(0, 1)),
             16'($urandom), 8'($urandom_range(0, 255)), 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule